// File: doc/BRIEF.md
# LCD Dot Clock Enable Generator

This block makes the two timing strobes an LCD controller needs, without creating any new clock nets. Three source tick lines arrive as levels that are sampled in the system clock domain: a bus-rate tick, a peripheral-rate tick and an external LCD tick. A 16-bit control register picks one of them and sets a divide ratio. Every rising edge of the chosen tick advances a first divider. After the programmed number of edges it issues a one-cycle dot enable.

A second stage derives the panel shift enable from the dot enable. For an active-matrix (TFT) panel the shift enable is the dot enable itself. For a passive (STN/DSTN) panel it fires once for every W dot enables, where W is the width of the output data bus to the panel. The panel type and the bus width come in on static configuration pins. Software reads and writes the register as a whole word through a write strobe and an always-valid read bus. There is no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `lcd_dotclk_gen`

## Requirements
- R1: Reset state: after reset the register reads 16'h0101 (select 00, ratio 1). `dot_en`, `shift_en` and `cfg_err` are all low.
- R2: Register layout:
  - bits 15:14 hold the source select and read back what was written;
  - bits 5:0 hold the ratio field and read back what was written;
  - bit 8 always reads 1;
  - bits 13:9 and 7:6 always read 0.
  Writes to the fixed bits have no effect. The register updates at the clock edge where `reg_wr` is high.
- R3: Source selection: select 00 uses `tick_bus`, 01 uses `tick_per` and 10 uses `tick_ext`. Only a 0-to-1 transition of the chosen line, seen between two clock samples, counts as an edge. A line held high counts once. Activity on the lines that are not selected has no effect.
- R4: Select 11 is a configuration error. `cfg_err` is high while it is set, and no `dot_en` pulse is produced.
- R5: With ratio field N in 1..32, `dot_en` pulses once per N counted edges. Field value 0 divides by 1, and any value above 32 divides by 32.
- R6: `dot_en` is a single-cycle pulse. It rises in the cycle after the clock edge that samples the counted edge. With edges every two cycles, successive pulses are exactly 2·N cycles apart.
- R7: When `panel_stn` is 0 (TFT), `shift_en` equals `dot_en` in every cycle.
- R8: When `panel_stn` is 1 (STN/DSTN), `shift_en` pulses once per W `dot_en` pulses, one cycle after the W-th pulse. The width code maps as 00→4, 01→8, 10→16 and 11→16.
- R9: Any change on `panel_stn` or `bus_width` restarts the second-stage count from zero.
- R10: Any register write clears both divider counts. No `dot_en` pulse appears in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_bus | input | 1 | Bus-rate source tick (level, sampled) |
| tick_per | input | 1 | Peripheral-rate source tick (level, sampled) |
| tick_ext | input | 1 | External LCD source tick (level, sampled) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, always valid |
| panel_stn | input | 1 | 0 = TFT panel, 1 = STN/DSTN panel |
| bus_width | input | 2 | Panel data bus width code (00:4, 01:8, 1x:16) |
| dot_en | output | 1 | Dot clock enable pulse |
| shift_en | output | 1 | Panel shift clock enable pulse |
| cfg_err | output | 1 | Prohibited source select is set |

## Verification
The bench sweeps every legal source against ratio field values 0 to 34. This covers both clamp boundaries; a design that did not clamp would wrap or stall at 0 and 33, and would give the wrong pulse count or spacing. Every width code, including the reserved 11, is run in passive-panel mode. A wrong divider there shows up as a wrong shift count. Two cases exist only to catch stale state: a rewrite in the middle of a count, and a width change in the middle of a line. A design that kept the old count would emit an early pulse in either case. Further runs toggle only the unselected lines, hold a tick high for many cycles and set the prohibited select. A design that decoded the mux wrongly, counted levels instead of edges, or kept dividing under the error setting would produce extra dot pulses.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;

  localparam int REG_W    = 16;
  localparam int RATIO_W  = 6;
  localparam int MAX_DIV  = 32;
  localparam int DIV_CW   = $clog2(MAX_DIV);
  localparam int LINE_CW  = 4;
  localparam int NUM_SRC  = 3;

  localparam int SEL_HI   = 15;
  localparam int SEL_LO   = 14;
  localparam int ONE_BIT  = 8;

  typedef enum logic [1:0] {
    SRC_BUS = 2'b00,
    SRC_PER = 2'b01,
    SRC_EXT = 2'b10,
    SRC_BAD = 2'b11
  } src_sel_e;

  // Terminal count (divide ratio minus one) with clamping of 0 and >MAX_DIV.
  function automatic logic [DIV_CW-1:0] ratio_term(input logic [RATIO_W-1:0] r);
    logic [RATIO_W-1:0] t;
    if (r == '0)
      t = '0;
    else if (r > RATIO_W'(MAX_DIV))
      t = RATIO_W'(MAX_DIV - 1);
    else
      t = r - RATIO_W'(1);
    return t[DIV_CW-1:0];
  endfunction

  // Terminal count of the line divider from the bus width code.
  function automatic logic [LINE_CW-1:0] width_term(input logic [1:0] code);
    case (code)
      2'b00:   return LINE_CW'(3);
      2'b01:   return LINE_CW'(7);
      default: return LINE_CW'(15);
    endcase
  endfunction

endpackage

// File: rtl/lcdclk_edge_det.sv
module lcdclk_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_src
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q;
  end

endmodule

// File: rtl/lcdclk_ctrl_reg.sv
module lcdclk_ctrl_reg
  import lcdclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output src_sel_e           sel,
  output logic [RATIO_W-1:0] ratio
);

  logic [1:0]         sel_q;
  logic [RATIO_W-1:0] ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 2'b00;
      ratio_q <= RATIO_W'(1);
    end else if (wr) begin
      sel_q   <= wdata[SEL_HI:SEL_LO];
      ratio_q <= wdata[RATIO_W-1:0];
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[SEL_HI:SEL_LO]  = sel_q;
    rdata[ONE_BIT]        = 1'b1;
    rdata[RATIO_W-1:0]    = ratio_q;
  end

  assign sel   = src_sel_e'(sel_q);
  assign ratio = ratio_q;

endmodule

// File: rtl/lcdclk_div.sv
module lcdclk_div #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] term,
  output logic          pulse
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (adv) begin
        if (cnt_q >= term) begin
          cnt_q <= '0;
          pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lcd_dotclk_gen.sv
module lcd_dotclk_gen
  import lcdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_bus,
  input  logic             tick_per,
  input  logic             tick_ext,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             panel_stn,
  input  logic [1:0]       bus_width,
  output logic             dot_en,
  output logic             shift_en,
  output logic             cfg_err
);

  logic [NUM_SRC-1:0] src_lvl, src_rise;
  src_sel_e           sel;
  logic [RATIO_W-1:0] ratio;
  logic               adv_dot;
  logic               line_pulse;
  logic [2:0]         cfg_q;
  logic               cfg_chg;

  assign src_lvl = {tick_ext, tick_per, tick_bus};

  lcdclk_edge_det #(.N(NUM_SRC)) u_edge (
    .clk (clk), .rst_n (rst_n), .lvl (src_lvl), .rise (src_rise)
  );

  lcdclk_ctrl_reg u_reg (
    .clk (clk), .rst_n (rst_n), .wr (reg_wr), .wdata (reg_wdata),
    .rdata (reg_rdata), .sel (sel), .ratio (ratio)
  );

  always_comb begin
    case (sel)
      SRC_BUS: adv_dot = src_rise[0];
      SRC_PER: adv_dot = src_rise[1];
      SRC_EXT: adv_dot = src_rise[2];
      default: adv_dot = 1'b0;
    endcase
  end

  assign cfg_err = (sel == SRC_BAD);

  lcdclk_div #(.CW(DIV_CW)) u_dot (
    .clk (clk), .rst_n (rst_n), .clr (reg_wr), .adv (adv_dot),
    .term (ratio_term(ratio)), .pulse (dot_en)
  );

  // Track panel configuration so a change restarts the line divider.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {panel_stn, bus_width};
  end
  assign cfg_chg = (cfg_q != {panel_stn, bus_width});

  lcdclk_div #(.CW(LINE_CW)) u_line (
    .clk (clk), .rst_n (rst_n), .clr (reg_wr | cfg_chg), .adv (dot_en),
    .term (width_term(bus_width)), .pulse (line_pulse)
  );

  assign shift_en = panel_stn ? line_pulse : dot_en;

endmodule

// File: rtl/lcdclk_chk.sv
module lcdclk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        panel_stn,
  input logic        dot_en,
  input logic        shift_en,
  input logic        cfg_err
);

  // R6
  dot_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en |=> !dot_en);

  // R4
  err_blocks_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !dot_en);

  // R8
  stn_shift_after_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_stn && shift_en) |-> $past(dot_en));

  // R10
  write_clears_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !dot_en);

  // R2
  readback_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[15:14] == $past(reg_wdata[15:14]) &&
                reg_rdata[5:0]   == $past(reg_wdata[5:0])));

endmodule

bind lcd_dotclk_gen lcdclk_chk u_chk (
  .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata), .panel_stn (panel_stn), .dot_en (dot_en),
  .shift_en (shift_en), .cfg_err (cfg_err)
);

// File: tb/sim_lcd_dotclk_gen.sv
module sim_lcd_dotclk_gen;

  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  ticks = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        panel_stn = 0;
  logic [1:0]  bus_width = '0;
  logic        dot_en, shift_en, cfg_err;

  int nchk = 0, nfail = 0;
  int cyc = 0, dcnt = 0, scnt = 0, last_d = -1, gap_exp = 0, gap_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_dotclk_gen u0 (
    .clk (clk), .rst_n (rst_n), .tick_bus (ticks[0]), .tick_per (ticks[1]),
    .tick_ext (ticks[2]), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .panel_stn (panel_stn), .bus_width (bus_width),
    .dot_en (dot_en), .shift_en (shift_en), .cfg_err (cfg_err)
  );

  always @(negedge clk) begin
    cyc++;
    if (dot_en) begin
      if (last_d >= 0 && gap_exp > 0 && (cyc - last_d) != gap_exp) gap_err++;
      last_d = cyc;
      dcnt++;
    end
    if (shift_en) scnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic clear_counts();
    dcnt = 0; scnt = 0; last_d = -1; gap_err = 0;
  endtask

  task automatic pulse_mask(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ticks = m;
      @(negedge clk); ticks = '0;
    end
  endtask

  task automatic flush();
    repeat (4) @(negedge clk);
  endtask

  function automatic int neff(input int r);
    if (r == 0) return 1;
    if (r > 32) return 32;
    return r;
  endfunction

  function automatic int wval(input int c);
    return (c == 0) ? 4 : (c == 1) ? 8 : 16;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 16'h0101);
    chk("R1 dot_en", dot_en, 0);
    chk("R1 shift_en", shift_en, 0);
    chk("R1 cfg_err", cfg_err, 0);

    // R2 fixed bits and readback
    wr(16'hFFFF);
    chk("R2 all-ones readback", reg_rdata, 16'hC13F);
    chk("R4 cfg_err on 11", cfg_err, 1);
    wr(16'h0000);
    chk("R2 all-zeros readback", reg_rdata, 16'h0100);
    chk("R4 cfg_err clear", cfg_err, 0);

    // R4 prohibited select blocks dot pulses
    wr(16'hC001);
    clear_counts();
    pulse_mask(3'b111, 20);
    flush();
    chk("R4 no dot under select 11", dcnt, 0);

    // R3 unselected sources ignored
    wr(16'h0001);
    clear_counts();
    pulse_mask(3'b110, 20);
    flush();
    chk("R3 unselected ignored", dcnt, 0);

    // R3 held-high tick counts once
    clear_counts();
    @(negedge clk); ticks = 3'b001;
    repeat (10) @(negedge clk);
    ticks = '0;
    flush();
    chk("R3 level counted once", dcnt, 1);

    // R5/R6/R7 sweep: every source, ratio 0..34, TFT panel
    panel_stn = 0;
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r <= 34; r++) begin
        wr({2'(s), 8'h00, 6'(r)});
        clear_counts();
        gap_exp = 2 * neff(r);
        pulse_mask(3'(1 << s), 70);
        flush();
        chk($sformatf("R5 src%0d ratio%0d count", s, r), dcnt, 70 / neff(r));
        chk($sformatf("R6 src%0d ratio%0d spacing", s, r), gap_err, 0);
        chk($sformatf("R7 src%0d ratio%0d tft shift", s, r), scnt, dcnt);
      end
    end
    gap_exp = 0;

    // R10 write clears count
    wr(16'h0004);
    clear_counts();
    pulse_mask(3'b001, 3);
    wr(16'h0004);
    pulse_mask(3'b001, 3);
    flush();
    chk("R10 rewrite restarts dot count", dcnt, 0);

    // R8 STN sweep over width codes and small ratios
    panel_stn = 1;
    for (int w = 0; w < 4; w++) begin
      for (int r = 1; r <= 3; r++) begin
        @(negedge clk); bus_width = 2'(w);
        repeat (2) @(negedge clk);
        wr({2'b00, 8'h00, 6'(r)});
        clear_counts();
        pulse_mask(3'b001, 96);
        flush();
        chk($sformatf("R8 w%0d r%0d dots", w, r), dcnt, 96 / r);
        chk($sformatf("R8 w%0d r%0d shifts", w, r), scnt, (96 / r) / wval(w));
      end
    end

    // R9 width change restarts line count
    @(negedge clk); bus_width = 2'b00;
    repeat (2) @(negedge clk);
    wr(16'h0001);
    clear_counts();
    pulse_mask(3'b001, 3);
    flush();
    @(negedge clk); bus_width = 2'b01;
    repeat (2) @(negedge clk);
    pulse_mask(3'b001, 7);
    flush();
    chk("R9 no early shift after width change", scnt, 0);
    pulse_mask(3'b001, 1);
    flush();
    chk("R9 shift on eighth dot", scnt, 1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule